// File: doc/BRIEF.md
# Action/Value Command Register Front End

This block is the software-facing control port of an error-record store. Software sees two 64-bit registers: a command register at byte offset 0 and a data register at byte offset 8. It loads parameters into the data register and then writes a command code to the command register. That command write is the only thing that has a side effect. It can latch an operation, copy the data register into the record offset or record identifier, start the latched operation, or fill the data register with status or parameters. Reads return register contents and change nothing.

The record storage and the copy datapath sit outside the block. To run an operation, the block sends a one-cycle start pulse together with the operation code, the record offset and the record identifier. It then holds a busy flag until the engine returns a one-cycle done pulse that carries an 8-bit status. An execute command only takes effect when the low byte of the data register holds the key value 0x9C.

Top module: `cmdRegIf`

## Requirements
- R1: After reset: busy is 0, engStart is 0, the command status is 0x00, the record identifier and record offset are 0, the data register reads 0, and no operation is latched.
- R2: An access is 64-bit when bus64=1 and 32-bit otherwise. A 32-bit access selects the upper half of a register when address bit 2 is 1. A 32-bit data write takes busWdata[31:0] into the selected half and leaves the other half unchanged. A 32-bit read returns the selected half in busRdata[31:0] with the upper bits 0. A 64-bit access uses offsets 0 and 8 only.
- R3: The command codes 0x00 (begin write), 0x01 (begin read), 0x02 (begin clear), 0x03 (end) and 0x0B (begin dummy write) only latch the code as the current operation, which engOp then shows. They raise no start and do not change the data register.
- R4: Command 0x05 (execute) with the key present and operation 0x00, 0x01 or 0x02 latched does the following. engStart is 1 for exactly the cycle after the command write, and busy rises in that same cycle. Busy stays 1 until the clock edge that samples engDone. At that edge the command status takes engStatus.
- R5: An execute whose data register low byte differs from 0x9C starts nothing and leaves busy and the status unchanged.
- R6: An execute with 0x03 or 0x0B latched sets the status to 0x00 without a start. An execute with no valid operation latched sets the status to 0x03.
- R7: While busy is 1, execute commands are ignored: no further start pulse is raised.
- R8: Command 0x04 copies the data register into the record offset (engOffset). Command 0x09 copies it into the record identifier (engRecId).
- R9: The following commands load the data register:
  - 0x06 loads the busy flag in bit 0.
  - 0x07 loads the status.
  - 0x0A loads recCount.
  - 0x0D loads logBase.
  - 0x0E loads logLength.
  - 0x0F loads 0.
  - 0x10 loads 100 in bits 63:32 and 10 in bits 31:0.
  - 0x08 loads nextRecId and sets the status to 0x00.
- R10: Unknown command codes, 32-bit writes to offset 4 and accesses outside offsets 0 to 15 have no effect. Reads outside the map return 0.
- R11: When engDone arrives in the same cycle as a 0x07 command, the data register receives the engine's new status.
- R12: Reading the command register returns the last command code written, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Byte address of the access |
| bus64 | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| busWdata | input | 64 | Write data |
| busRdata | output | 64 | Read data, combinational from busAddr and bus64 |
| engStart | output | 1 | One-cycle start pulse to the record engine |
| engOp | output | 8 | Latched operation code |
| engOffset | output | OFF_W | Record offset |
| engRecId | output | 64 | Record identifier |
| engDone | input | 1 | Engine completion pulse |
| engStatus | input | 8 | Completion status, valid with engDone |
| recCount | input | CNT_W | Current record count |
| logBase | input | 64 | Base address of the exchange buffer |
| logLength | input | LEN_W | Length of the exchange buffer |
| nextRecId | input | 64 | Next record identifier from the engine's scan |
| busy | output | 1 | An operation is in flight |

## Verification
Two things can fall in the same clock cycle: the engine's completion pulse and a software command that reports state. The case that matters is a get-status command issued while busy. The bench drives engDone with a fresh status value in the same cycle as the 0x07 command write. It then requires that the data register holds the engine's new status, not the stale one, and that busy has dropped. Separately, it issues an execute while busy is still high and requires that no second start pulse appears.

// File: rtl/cri_pkg.sv
package cri_pkg;

  localparam logic [31:0] CMD_BEG_WR   = 32'h00;
  localparam logic [31:0] CMD_BEG_RD   = 32'h01;
  localparam logic [31:0] CMD_BEG_CLR  = 32'h02;
  localparam logic [31:0] CMD_END      = 32'h03;
  localparam logic [31:0] CMD_SET_OFF  = 32'h04;
  localparam logic [31:0] CMD_EXEC     = 32'h05;
  localparam logic [31:0] CMD_GET_BUSY = 32'h06;
  localparam logic [31:0] CMD_GET_STAT = 32'h07;
  localparam logic [31:0] CMD_GET_ID   = 32'h08;
  localparam logic [31:0] CMD_SET_ID   = 32'h09;
  localparam logic [31:0] CMD_GET_CNT  = 32'h0A;
  localparam logic [31:0] CMD_BEG_DUMY = 32'h0B;
  localparam logic [31:0] CMD_GET_BASE = 32'h0D;
  localparam logic [31:0] CMD_GET_LEN  = 32'h0E;
  localparam logic [31:0] CMD_GET_ATTR = 32'h0F;
  localparam logic [31:0] CMD_GET_TIME = 32'h10;

  localparam logic [7:0] OP_NONE   = 8'hFF;
  localparam logic [7:0] STAT_OK   = 8'h00;
  localparam logic [7:0] STAT_FAIL = 8'h03;

  typedef enum logic [3:0] {
    VS_NONE, VS_BUSY, VS_STATUS, VS_NEXTID, VS_COUNT,
    VS_BASE, VS_LEN, VS_ATTR, VS_TIMING
  } valSrc_e;

  typedef struct packed {
    valSrc_e    valSrc;
    logic       ldOffset;
    logic       ldId;
    logic       setStatus;
    logic [7:0] statusCode;
    logic       busyVal;
    logic       engFinish;
  } ctrlStrobes_t;

endpackage

// File: rtl/cri_ctrl.sv
module cri_ctrl
  import cri_pkg::*;
#(
  parameter logic [7:0] EXEC_KEY = 8'h9C
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         actWr,
  input  logic [31:0]  actCode,
  input  logic [7:0]   valLowByte,
  input  logic         engDone,
  output ctrlStrobes_t st,
  output logic         busy,
  output logic         engStart,
  output logic [7:0]   engOp,
  output logic [31:0]  actReg
);

  logic launch;
  logic latchOp;

  always_comb begin
    st = '0;
    st.valSrc = VS_NONE;
    st.busyVal = busy;
    st.engFinish = busy && engDone;
    launch = 1'b0;
    latchOp = 1'b0;
    if (actWr) begin
      case (actCode)
        CMD_BEG_WR, CMD_BEG_RD, CMD_BEG_CLR, CMD_END, CMD_BEG_DUMY: latchOp = 1'b1;
        CMD_SET_OFF:  st.ldOffset = 1'b1;
        CMD_SET_ID:   st.ldId = 1'b1;
        CMD_EXEC: begin
          if (valLowByte == EXEC_KEY && !busy) begin
            if (engOp == CMD_END[7:0] || engOp == CMD_BEG_DUMY[7:0]) begin
              st.setStatus = 1'b1;
              st.statusCode = STAT_OK;
            end else if (engOp == CMD_BEG_WR[7:0] || engOp == CMD_BEG_RD[7:0] ||
                         engOp == CMD_BEG_CLR[7:0]) begin
              launch = 1'b1;
            end else begin
              st.setStatus = 1'b1;
              st.statusCode = STAT_FAIL;
            end
          end
        end
        CMD_GET_BUSY: st.valSrc = VS_BUSY;
        CMD_GET_STAT: st.valSrc = VS_STATUS;
        CMD_GET_ID: begin
          st.valSrc = VS_NEXTID;
          st.setStatus = 1'b1;
          st.statusCode = STAT_OK;
        end
        CMD_GET_CNT:  st.valSrc = VS_COUNT;
        CMD_GET_BASE: st.valSrc = VS_BASE;
        CMD_GET_LEN:  st.valSrc = VS_LEN;
        CMD_GET_ATTR: st.valSrc = VS_ATTR;
        CMD_GET_TIME: st.valSrc = VS_TIMING;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      engOp    <= OP_NONE;
      busy     <= 1'b0;
      engStart <= 1'b0;
      actReg   <= '0;
    end else begin
      engStart <= launch;
      if (latchOp) engOp <= actCode[7:0];
      if (actWr) actReg <= actCode;
      if (launch) busy <= 1'b1;
      else if (engDone) busy <= 1'b0;
    end
  end

  AST_START_WITH_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> busy); // R4
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    engStart |=> !engStart); // R4
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> !$past(busy)); // R7
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && engDone && !engStart) |=> !busy); // R4
  AST_KEY_GATES: assert property (@(posedge clk) disable iff (!rstN)
    (actWr && actCode == CMD_EXEC && valLowByte != EXEC_KEY) |=> !engStart); // R5

endmodule

// File: rtl/cri_datapath.sv
module cri_datapath
  import cri_pkg::*;
#(
  parameter int OFF_W = 32,
  parameter int CNT_W = 32,
  parameter int LEN_W = 32,
  parameter logic [31:0] TMAX_US = 32'd100,
  parameter logic [31:0] TMIN_US = 32'd10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         valWr,
  input  logic         valUpper,
  input  logic         val64,
  input  logic [63:0]  wdata,
  input  ctrlStrobes_t st,
  input  logic [7:0]   engStatus,
  input  logic [CNT_W-1:0] recCount,
  input  logic [63:0]  logBase,
  input  logic [LEN_W-1:0] logLength,
  input  logic [63:0]  nextRecId,
  output logic [63:0]  value,
  output logic [OFF_W-1:0] recOffset,
  output logic [63:0]  recId,
  output logic [7:0]   status
);

  logic [7:0] statusNow;
  assign statusNow = st.engFinish ? engStatus : status;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      value     <= '0;
      recOffset <= '0;
      recId     <= '0;
      status    <= STAT_OK;
    end else begin
      if (valWr) begin
        if (val64)         value <= wdata;
        else if (valUpper) value[63:32] <= wdata[31:0];
        else               value[31:0]  <= wdata[31:0];
      end else begin
        case (st.valSrc)
          VS_BUSY:   value <= {63'd0, st.busyVal};
          VS_STATUS: value <= {56'd0, statusNow};
          VS_NEXTID: value <= nextRecId;
          VS_COUNT:  value <= 64'(recCount);
          VS_BASE:   value <= logBase;
          VS_LEN:    value <= 64'(logLength);
          VS_ATTR:   value <= '0;
          VS_TIMING: value <= {TMAX_US, TMIN_US};
          default: ;
        endcase
      end
      if (st.ldOffset) recOffset <= value[OFF_W-1:0];
      if (st.ldId)     recId <= value;
      status <= st.setStatus ? st.statusCode : statusNow;
    end
  end

  AST_STATUS_FROM_ENGINE: assert property (@(posedge clk) disable iff (!rstN)
    (st.engFinish && !st.setStatus) |=> status == $past(engStatus)); // R4
  AST_ID_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !st.ldId |=> recId == $past(recId)); // R8

endmodule

// File: rtl/cmdRegIf.sv
module cmdRegIf
  import cri_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int OFF_W  = 32,
  parameter int CNT_W  = 32,
  parameter int LEN_W  = 32,
  parameter logic [7:0] EXEC_KEY = 8'h9C,
  parameter logic [31:0] TMAX_US = 32'd100,
  parameter logic [31:0] TMIN_US = 32'd10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              bus64,
  input  logic [63:0]       busWdata,
  output logic [63:0]       busRdata,
  output logic              engStart,
  output logic [7:0]        engOp,
  output logic [OFF_W-1:0]  engOffset,
  output logic [63:0]       engRecId,
  input  logic              engDone,
  input  logic [7:0]        engStatus,
  input  logic [CNT_W-1:0]  recCount,
  input  logic [63:0]       logBase,
  input  logic [LEN_W-1:0]  logLength,
  input  logic [63:0]       nextRecId,
  output logic              busy
);

  localparam int HI_W = ADDR_W - 4;

  ctrlStrobes_t st;
  logic [63:0]  value;
  logic [31:0]  actReg;
  logic [7:0]   status;
  logic         mapped, isVal, isUpper, actWr, valWr;

  assign mapped  = (busAddr[ADDR_W-1:4] == HI_W'(0)) && (busAddr[1:0] == 2'b00) &&
                   !(bus64 && busAddr[2]);
  assign isVal   = busAddr[3];
  assign isUpper = busAddr[2];
  assign actWr   = busWr && mapped && !isVal && !isUpper;
  assign valWr   = busWr && mapped && isVal;

  always_comb begin
    busRdata = '0;
    if (mapped) begin
      if (bus64)        busRdata = isVal ? value : {32'd0, actReg};
      else if (isVal)   busRdata = {32'd0, isUpper ? value[63:32] : value[31:0]};
      else if (!isUpper) busRdata = {32'd0, actReg};
    end
  end

  cri_ctrl #(.EXEC_KEY(EXEC_KEY)) uCtrl (
    .clk(clk), .rstN(rstN), .actWr(actWr), .actCode(busWdata[31:0]),
    .valLowByte(value[7:0]), .engDone(engDone), .st(st), .busy(busy),
    .engStart(engStart), .engOp(engOp), .actReg(actReg)
  );

  cri_datapath #(.OFF_W(OFF_W), .CNT_W(CNT_W), .LEN_W(LEN_W),
                 .TMAX_US(TMAX_US), .TMIN_US(TMIN_US)) uDp (
    .clk(clk), .rstN(rstN), .valWr(valWr), .valUpper(isUpper), .val64(bus64),
    .wdata(busWdata), .st(st), .engStatus(engStatus), .recCount(recCount),
    .logBase(logBase), .logLength(logLength), .nextRecId(nextRecId),
    .value(value), .recOffset(engOffset), .recId(engRecId), .status(status)
  );

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !mapped |-> busRdata == 64'd0); // R10

endmodule

// File: tb/cmdRegIf_test.sv
module cmdRegIf_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0, busWr = 0, bus64 = 0, engDone = 0;
  logic [4:0] busAddr = 0;
  logic [63:0] busWdata = 0, busRdata, engRecId, logBase = 0, nextRecId = 0;
  logic engStart, busy;
  logic [7:0] engOp, engStatus = 0;
  logic [31:0] engOffset, recCount = 0, logLength = 0;
  int nChecks = 0, nFails = 0, cyc = 0;
  bit done = 0;
  logic [63:0] mv, rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdRegIf uut (.clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .bus64(bus64),
    .busWdata(busWdata), .busRdata(busRdata), .engStart(engStart), .engOp(engOp),
    .engOffset(engOffset), .engRecId(engRecId), .engDone(engDone), .engStatus(engStatus),
    .recCount(recCount), .logBase(logBase), .logLength(logLength), .nextRecId(nextRecId),
    .busy(busy));

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] merge(logic [63:0] old, logic [63:0] d, bit w64, bit up);
    if (w64) return d;
    if (up) return {d[31:0], old[31:0]};
    return {old[63:32], d[31:0]};
  endfunction

  task automatic wr(logic [4:0] a, logic [63:0] d, bit w64);
    @(negedge clk);
    busWr = 1; busAddr = a; busWdata = d; bus64 = w64;
    @(negedge clk);
    busWr = 0;
  endtask

  task automatic rdReg(logic [4:0] a, bit w64, output logic [63:0] d);
    busAddr = a; bus64 = w64;
    #1 d = busRdata;
  endtask

  task automatic act(logic [31:0] c);
    wr(5'd0, {32'd0, c}, 0);
  endtask

  task automatic readVal(output logic [63:0] d);
    rdReg(5'd8, 1, d);
  endtask

  task automatic getStatus(output logic [63:0] d);
    act(32'h7); readVal(d);
  endtask

  task automatic finishEng(logic [7:0] s);
    @(negedge clk);
    engDone = 1; engStatus = s;
    @(negedge clk);
    engDone = 0;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got %0d expected below 50000 cycles", cyc);
      summary();
    end
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    readVal(rd); check("R1 value", rd, 0);
    rdReg(5'd0, 1, rd); check("R1 action", rd, 0);
    check("R1 busy", busy, 0);
    check("R1 start", engStart, 0);
    check("R1 offset", engOffset, 0);
    check("R1 id", engRecId, 0);
    check("R1 op none", engOp, 8'hFF);
    getStatus(rd); check("R1 status", rd, 0);

    // R2 random 32/64 accesses to the data register
    wr(5'd8, 64'd0, 1); mv = 0;
    for (int i = 0; i < 40; i++) begin
      logic [63:0] d;
      bit w64, up;
      d = {$urandom, $urandom}; w64 = $urandom % 2; up = w64 ? 0 : $urandom % 2;
      wr(up ? 5'd12 : 5'd8, d, w64);
      mv = merge(mv, d, w64, up);
      rdReg(5'd8, 0, rd); check("R2 low half", rd, {32'd0, mv[31:0]});
      rdReg(5'd12, 0, rd); check("R2 high half", rd, {32'd0, mv[63:32]});
      readVal(rd); check("R2 full", rd, mv);
    end

    // R8 offset and identifier
    wr(5'd8, 64'h0000_0000_0000_1234, 1); act(32'h4);
    check("R8 offset", engOffset, 32'h1234);
    wr(5'd8, 64'hDEAD_BEEF_0BAD_F00D, 1); act(32'h9);
    check("R8 id", engRecId, 64'hDEAD_BEEF_0BAD_F00D);

    // R3 begin only latches
    act(32'h1);
    check("R3 op", engOp, 8'h01); check("R3 start", engStart, 0);
    readVal(rd); check("R3 value kept", rd, 64'hDEAD_BEEF_0BAD_F00D);
    act(32'h0); check("R3 op write", engOp, 8'h00);

    // R5 wrong key
    wr(5'd8, 64'h9B, 1); act(32'h5);
    check("R5 start", engStart, 0); check("R5 busy", busy, 0);
    getStatus(rd); check("R5 status", rd, 0);

    // R4 full execute
    wr(5'd8, 64'h9C, 1); act(32'h5);
    check("R4 start", engStart, 1); check("R4 busy", busy, 1);
    @(negedge clk);
    check("R4 start pulse", engStart, 0); check("R4 busy held", busy, 1);
    // R7 execute while busy ignored
    act(32'h5); check("R7 no restart", engStart, 0);
    repeat (2) @(negedge clk);
    finishEng(8'h05);
    check("R4 busy cleared", busy, 0);
    getStatus(rd); check("R4 status", rd, 5);

    // R6 dummy and end
    act(32'hB); wr(5'd8, 64'h9C, 1); act(32'h5);
    check("R6 dummy no start", engStart, 0);
    getStatus(rd); check("R6 dummy status", rd, 0);

    // R9 reporting commands
    recCount = $urandom; logBase = {$urandom, $urandom}; logLength = $urandom;
    nextRecId = {$urandom, $urandom};
    act(32'hA); readVal(rd); check("R9 count", rd, {32'd0, recCount});
    act(32'hD); readVal(rd); check("R9 base", rd, logBase);
    act(32'hE); readVal(rd); check("R9 length", rd, {32'd0, logLength});
    act(32'hF); readVal(rd); check("R9 attr", rd, 0);
    act(32'h10); readVal(rd); check("R9 timings", rd, {32'd100, 32'd10});
    act(32'h6); readVal(rd); check("R9 busy idle", rd, 0);

    // R11 done in the same cycle as get-status; R9 busy while active
    act(32'h2); wr(5'd8, 64'h9C, 1); act(32'h5);
    check("R4 clear start", engOp, 8'h02);
    act(32'h6); readVal(rd); check("R9 busy active", rd, 1);
    @(negedge clk);
    busWr = 1; busAddr = 0; bus64 = 0; busWdata = 64'h7; engDone = 1; engStatus = 8'h42;
    @(negedge clk);
    busWr = 0; engDone = 0;
    readVal(rd); check("R11 forwarded status", rd, 64'h42);
    check("R11 busy dropped", busy, 0);

    // R9 get id sets status OK
    act(32'h8); readVal(rd); check("R9 next id", rd, nextRecId);
    getStatus(rd); check("R9 id status", rd, 0);

    // R10 ignored accesses
    wr(5'd8, 64'h1111_2222_3333_4444, 1);
    act(32'hC); act(32'h11); act(32'h105);
    readVal(rd); check("R10 unknown codes", rd, 64'h1111_2222_3333_4444);
    wr(5'd16, 64'hFFFF, 1); wr(5'd24, 64'hFFFF, 1);
    readVal(rd); check("R10 unmapped write", rd, 64'h1111_2222_3333_4444);
    rdReg(5'd24, 1, rd); check("R10 unmapped read", rd, 0);
    wr(5'd4, 64'h5, 0);
    rdReg(5'd0, 1, rd); check("R10 action upper write", rd, 64'h105);
    check("R10 no exec", engStart, 0);

    // R12 command register readback
    act(32'h7); rdReg(5'd0, 0, rd); check("R12 action", rd, 7);

    // R6 end and none latched
    act(32'h3); wr(5'd8, 64'h9C, 1); act(32'h5);
    getStatus(rd); check("R6 end status", rd, 0);
    @(negedge clk); rstN = 0; @(negedge clk); rstN = 1;
    wr(5'd8, 64'h9C, 1); act(32'h5);
    check("R6 none no start", engStart, 0);
    getStatus(rd); check("R6 none failed", rd, 3);

    summary();
  end
endmodule